// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational integer datapath element. It takes two operand words and a three-bit operation code. It returns one result word and three condition flags: zero, overflow and carry. The operations are bitwise AND, bitwise OR, addition, subtraction and a set-on-less-than compare. All of the arithmetic operations share one ripple-carry adder built from per-bit slices. Subtraction inverts the second operand and injects a carry-in of one.

A separate mode input selects signed or unsigned interpretation. In signed mode, overflow is derived from the signs of the two adder inputs and the sign of the sum. In unsigned mode, overflow is held low. The less-than compare then uses the adder's borrow, taken as the inverted carry, instead of the sign. The block has no clock and no state, so the outputs follow the inputs within the same cycle.

Top module: `int_alu`

## Requirements
- R1: Operation code 3'b000 makes the result the bitwise AND of the two operands.
- R2: Operation code 3'b001 makes the result the bitwise OR of the two operands.
- R3: Operation code 3'b010 makes the result the low WIDTH bits of opa + opb. The carry flag is the bit the sum carries out of the top position.
- R4: Operation code 3'b110 makes the result opa - opb modulo 2^WIDTH. The carry flag is the carry out of opa + ~opb + 1, so it is 1 exactly when opa >= opb as unsigned values.
- R5: With is_unsigned = 0, the overflow flag is 1 for addition and subtraction exactly when the true signed result does not fit in WIDTH bits.
- R6: With is_unsigned = 1, the overflow flag is 0 for every operation code.
- R7: Operation code 3'b111 with is_unsigned = 0 sets result bit 0 to 1 when opa < opb as signed values, and to 0 otherwise. All other result bits are 0. The compare is correct even when opa - opb overflows.
- R8: Operation code 3'b111 with is_unsigned = 1 sets result bit 0 to 1 exactly when opa < opb as unsigned values. All other result bits are 0.
- R9: The zero flag is 1 exactly when every result bit is 0, for every operation code.
- R10: Operation codes 3'b011, 3'b100 and 3'b101 give a result of 0, with overflow and carry both 0. The zero flag is therefore 1.
- R11: For AND, OR and set-on-less-than, the overflow and carry flags are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| op_code | input | 3 | Operation select |
| is_unsigned | input | 1 | 1 selects unsigned interpretation |
| result | output | WIDTH | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| carry_flag | output | 1 | Carry out of the adder for add or subtract |

## Verification
The bench builds the unit at its default width of 32 bits. At that width the boundary words 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF reach every sign-change case of the overflow rule. They also cover a carry ripple through all 32 slices, and a signed compare whose subtraction overflows. A golden model in 64-bit arithmetic gives the expected results. Random operands then run under every operation code in both modes, including the unused codes.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       op_code,
  input  logic             is_unsigned,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag,
  output logic             carry_flag
);
  localparam int MSB = WIDTH - 1;

  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic             do_sub;
  logic [WIDTH-1:0] b_in;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   chain;
  logic             ovf_raw;
  logic             less;

  assign do_sub   = (op_code == OP_SUB) || (op_code == OP_SLT);
  assign b_in     = opb ^ {WIDTH{do_sub}};
  assign chain[0] = do_sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign sum[i]     = opa[i] ^ b_in[i] ^ chain[i];
    assign chain[i+1] = (opa[i] & b_in[i]) | (chain[i] & (opa[i] ^ b_in[i]));
  end

  assign ovf_raw = (opa[MSB] == b_in[MSB]) && (sum[MSB] != opa[MSB]);
  assign less    = is_unsigned ? ~chain[WIDTH] : (sum[MSB] ^ ovf_raw);

  always_comb begin
    result     = '0;
    ovf_flag   = 1'b0;
    carry_flag = 1'b0;
    case (op_code)
      OP_AND: result = opa & opb;
      OP_OR:  result = opa | opb;
      OP_ADD, OP_SUB: begin
        result     = sum;
        carry_flag = chain[WIDTH];
        ovf_flag   = ovf_raw & ~is_unsigned;
      end
      OP_SLT: result = {{(WIDTH-1){1'b0}}, less};
      default: ;
    endcase
  end

  assign zero_flag = ~|result;

  always_comb begin
    if (op_code == OP_ADD)
      a_r3_add_sum: assert ({carry_flag, result} == ({1'b0, opa} + {1'b0, opb}));
    if (op_code == OP_SUB)
      a_r4_sub_diff: assert (result == opa - opb && carry_flag == (opa >= opb));
    if (is_unsigned)
      a_r6_no_overflow: assert (!ovf_flag);
    if (op_code == OP_SLT)
      a_r7_slt_shape: assert (result[MSB:1] == '0);
    if (op_code == 3'b011 || op_code == 3'b100 || op_code == 3'b101)
      a_r10_unused_clear: assert (result == '0 && !ovf_flag && !carry_flag && zero_flag);
    if (op_code == OP_AND || op_code == OP_OR || op_code == OP_SLT)
      a_r11_flags_quiet: assert (!ovf_flag && !carry_flag);
  end
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         z;
    logic         v;
    logic         c;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [2:0]   op_code = 3'b000;
  logic         is_unsigned = 1'b0;
  logic [W-1:0] result;
  logic         zero_flag, ovf_flag, carry_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  int_alu #(.WIDTH(W)) uut (
    .opa(opa), .opb(opb), .op_code(op_code), .is_unsigned(is_unsigned),
    .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag),
    .carry_flag(carry_flag)
  );

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b,
                                 logic [2:0] op, logic um, string req);
    exp_t e;
    longint sa, sb, st;
    logic [W:0] wide;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e.res = '0; e.v = 1'b0; e.c = 1'b0; e.req = req;
    case (op)
      3'b000: e.res = a & b;
      3'b001: e.res = a | b;
      3'b010: begin
        wide = {1'b0, a} + {1'b0, b};
        e.res = wide[W-1:0]; e.c = wide[W];
        st = sa + sb;
        e.v = !um && (st > 64'sd2147483647 || st < -64'sd2147483648);
      end
      3'b110: begin
        e.res = a - b; e.c = (a >= b);
        st = sa - sb;
        e.v = !um && (st > 64'sd2147483647 || st < -64'sd2147483648);
      end
      3'b111: e.res = {{(W-1){1'b0}}, (um ? (a < b) : (sa < sb))};
      default: ;
    endcase
    e.z = (e.res == '0);
    return e;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op,
                       logic um, string req);
    @(posedge clk);
    opa <= a; opb <= b; op_code <= op; is_unsigned <= um;
    sb_q.push_back(model(a, b, op, um, req));
  endtask

  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (result !== e.res || zero_flag !== e.z || ovf_flag !== e.v || carry_flag !== e.c) begin
        failures++;
        $display("FAIL %s: got res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b",
                 e.req, result, zero_flag, ovf_flag, carry_flag, e.res, e.z, e.v, e.c);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== '0 || zero_flag !== 1'b1 || ovf_flag !== 1'b0 || carry_flag !== 1'b0) begin
      failures++;
      $display("FAIL R9 idle: got res=%h z=%b expected res=0 z=1", result, zero_flag);
    end
    rst = 1'b0;

    drive(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000, 0, "R1 and");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 3'b000, 0, "R1 and disjoint R9");
    drive(32'hAAAA_0000, 32'h0000_5555, 3'b001, 0, "R2 or");
    drive(32'h0000_0000, 32'h0000_0000, 3'b001, 1, "R2 or zero R9");
    drive(32'h0000_0005, 32'h0000_0007, 3'b010, 0, "R3 add");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, 0, "R3 carry ripple R9");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, 0, "R5 add ovf pos");
    drive(32'h8000_0000, 32'h8000_0000, 3'b010, 0, "R5 add ovf neg");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, 1, "R6 add unsigned");
    drive(32'h0000_0009, 32'h0000_0004, 3'b110, 0, "R4 sub");
    drive(32'h0000_0000, 32'h0000_0001, 3'b110, 0, "R4 sub borrow");
    drive(32'h1234_5678, 32'h1234_5678, 3'b110, 0, "R4 sub equal R9");
    drive(32'h8000_0000, 32'h0000_0001, 3'b110, 0, "R5 sub ovf");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, 0, "R5 sub ovf neg b");
    drive(32'h8000_0000, 32'h0000_0001, 3'b110, 1, "R6 sub unsigned");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, 0, "R7 slt ovf case R11");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, 0, "R7 slt ovf reverse");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b111, 0, "R7 slt neg");
    drive(32'h0000_0003, 32'h0000_0003, 3'b111, 0, "R7 slt equal");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, 1, "R8 slt unsigned");
    drive(32'h0000_0001, 32'hFFFF_FFFF, 3'b111, 1, "R8 slt unsigned less");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, 0, "R10 unused 011");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b100, 0, "R10 unused 100");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b101, 1, "R10 unused 101");

    for (int i = 0; i < 800; i++) begin
      logic [W-1:0] a, b;
      logic [2:0] op;
      a = $urandom; b = $urandom;
      if (i % 5 == 0) b = a;
      if (i % 7 == 0) a = {a[W-1], {(W-1){~a[W-1]}}};
      op = 3'(i % 8);
      drive(a, b, op, 1'(i / 8 % 2), "R1-R11 random (R5 R6 R7 R8 R9 R10)");
    end

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule